// File: doc/BRIEF.md
# Inverted-Data Synchronous Bus Bit Engine

This block is the bit layer of a half-duplex serial bus whose clock comes from a remote master. Clock, data and bus-enable arrive asynchronously and are brought into the local clock domain. One pass over eight bus clock periods both receives and transmits a byte. On each rising bus clock the block drives the next outgoing bit onto the shared wired-AND data line. On the matching falling bus clock it captures the level on that same line. A low level on the line means a logic 1, in both directions.

Each completed receive byte goes to the packet layer with a single-cycle strobe. On that same strobe the packet layer's next transmit byte is taken. While the bus enable is low, nothing is shifted and the line is released. Any byte that was in progress is dropped.

Top module: `busbit_shifter`

## Requirements
- R1: While reset is asserted, and after its release with idle inputs, `line_pull_o` is 0, `rx_byte_o` is 8'h00 and `byte_stb_o` is 0.
- R2: On each falling edge of the synchronised bus clock with enable high, the synchronised data level is inverted and shifted in, so a low line stores a 1. The first bit received becomes bit 7 of `rx_byte_o`.
- R3: After the eighth falling edge of a byte, `byte_stb_o` is high for exactly one clock, and `rx_byte_o` shows the new byte in that same cycle. `rx_byte_o` changes at no other time.
- R4: On a rising edge of the synchronised bus clock with enable high, `line_pull_o` takes the current transmit bit, most significant bit first. It returns to 0 on the next falling edge, so it is high only between a rise and a fall.
- R5: A transmit bit of 0 never pulls the line. A transmit byte of 8'h00 leaves the line released for the whole byte, so the master's data arrives unchanged.
- R6: The transmit byte for the following byte is taken from `tx_byte_i` in the cycle `byte_stb_o` is raised. While the enable is low, `tx_byte_i` is taken continuously, so the first byte after enable rises uses the value present then.
- R7: If the enable goes low partway through a byte, that byte is abandoned. No strobe is issued, the line is released, and the next byte starts again from its first bit.
- R8: While the enable is low, bus clock edges have no effect on any output.
- R9: All three bus inputs pass through two synchroniser stages. An output responds on the third clock edge after a bus input change is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock from master, asynchronous |
| bus_dat_i | input | 1 | Shared data line level, active low |
| bus_en_i | input | 1 | Bus enable, asynchronous |
| tx_byte_i | input | 8 | Next byte to transmit, from the packet layer |
| line_pull_o | output | 1 | 1 = pull data line low (open-drain control) |
| rx_byte_o | output | 8 | Last completed received byte |
| byte_stb_o | output | 1 | One-cycle pulse when a byte completes |

## Verification
The assertions assume that each bus clock level is held for many local clock cycles. Under that assumption, a detected rise and fall can never land in adjacent cycles. They also assume that the data line settles while the bus clock is high. The stimulus keeps every bus clock phase at ten local cycles. It changes master data only together with a rising bus clock, and it lowers the enable only while the bus clock is low. A behavioural reference fed from the same pins is compared against every output on every cycle. Transaction checks then confirm the bytes exchanged over the wired-AND line, where the received value is the OR of both senders' bits.

// File: rtl/busbit_pkg.sv
package busbit_pkg;
  localparam int unsigned BB_BITS   = 8;
  localparam int unsigned BB_CNT_W  = $clog2(BB_BITS);
  localparam int unsigned BB_STAGES = 2;
  typedef logic [BB_BITS-1:0] bb_byte_t;
endpackage

// File: rtl/bb_sync.sv
module bb_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bb_edge.sv
module bb_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  // R9: an edge cannot be reported twice in a row on a held level
  a_r9_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  a_r9_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/bb_engine.sv
module bb_engine
  import busbit_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     rise_i,
  input  logic     fall_i,
  input  logic     dat_i,
  input  bb_byte_t tx_byte_i,
  output logic     pull_o,
  output bb_byte_t rx_byte_o,
  output logic     stb_o
);
  localparam logic [BB_CNT_W-1:0] LAST_BIT = BB_CNT_W'(BB_BITS - 1);
  localparam logic [BB_CNT_W-1:0] ONE      = BB_CNT_W'(1);

  logic [BB_CNT_W-1:0] cnt_q, cnt_d;
  bb_byte_t            tx_q, tx_d;
  bb_byte_t            sh_q, sh_d;
  bb_byte_t            byte_q, byte_d;
  logic                pull_q, pull_d;
  logic                stb_q, stb_d;

  always_comb begin
    cnt_d  = cnt_q;
    tx_d   = tx_q;
    sh_d   = sh_q;
    byte_d = byte_q;
    pull_d = pull_q;
    stb_d  = 1'b0;
    if (!en_i) begin
      cnt_d  = '0;
      pull_d = 1'b0;
      tx_d   = tx_byte_i;
    end else if (rise_i) begin
      pull_d = tx_q[BB_BITS-1];
    end else if (fall_i) begin
      pull_d = 1'b0;
      sh_d   = {sh_q[BB_BITS-2:0], ~dat_i};
      if (cnt_q == LAST_BIT) begin
        cnt_d  = '0;
        byte_d = sh_d;
        stb_d  = 1'b1;
        tx_d   = tx_byte_i;
      end else begin
        cnt_d  = cnt_q + ONE;
        tx_d   = {tx_q[BB_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tx_q   <= '0;
      sh_q   <= '0;
      byte_q <= '0;
      pull_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
      sh_q   <= sh_d;
      byte_q <= byte_d;
      pull_q <= pull_d;
      stb_q  <= stb_d;
    end
  end

  assign pull_o    = pull_q;
  assign rx_byte_o = byte_q;
  assign stb_o     = stb_q;

  // R4: line is pulled only after an enabled rise, released after a fall
  a_r4_pull_from_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> $past(rise_i && en_i));
  a_r4_release_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && en_i) |=> !pull_q);
  // R3: strobe is a single cycle and follows an enabled fall
  a_r3_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  a_r3_strobe_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> $past(fall_i && en_i));
  a_r3_byte_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_q |-> $stable(byte_q));
  // R7 / R8: disabled bus is silent
  a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pull_q && !stb_q));
endmodule

// File: rtl/busbit_shifter.sv
module busbit_shifter
  import busbit_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_clk_i,
  input  logic                bus_dat_i,
  input  logic                bus_en_i,
  input  logic [BB_BITS-1:0]  tx_byte_i,
  output logic                line_pull_o,
  output logic [BB_BITS-1:0]  rx_byte_o,
  output logic                byte_stb_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [2:0] raw_in, sync_in;
  logic       clk_s, dat_s, en_s;
  logic       rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_in = {bus_en_i, bus_dat_i, bus_clk_i};

  bb_sync #(.WIDTH(3), .STAGES(BB_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .async_i(raw_in),
    .sync_o (sync_in)
  );

  assign clk_s = sync_in[0];
  assign dat_s = sync_in[1];
  assign en_s  = sync_in[2];

  bb_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .lvl_i (clk_s),
    .rise_o(rise),
    .fall_o(fall)
  );

  bb_engine u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .en_i     (en_s),
    .rise_i   (rise),
    .fall_i   (fall),
    .dat_i    (dat_s),
    .tx_byte_i(tx_byte_i),
    .pull_o   (line_pull_o),
    .rx_byte_o(rx_byte_o),
    .stb_o    (byte_stb_o)
  );

  // R1: reset leaves the line released and no strobe
  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_int_n |=> (!line_pull_o && !byte_stb_o));
endmodule

// File: tb/sim_busbit_shifter.sv
`timescale 1ns/1ps
module sim_busbit_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0, ben = 1'b0, mlow = 1'b0;
  logic [7:0] txb = 8'h00;
  logic       bdat, pull, stb;
  logic [7:0] rxb;
  int         checks = 0, fails = 0, cyc = 0, stb_cnt = 0;
  logic [7:0] last_rx = 8'h00;

  always #2.5 clk = ~clk;

  assign bdat = ~(mlow | pull);

  busbit_shifter u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bclk), .bus_dat_i(bdat),
    .bus_en_i(ben), .tx_byte_i(txb), .line_pull_o(pull),
    .rx_byte_o(rxb), .byte_stb_o(stb)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: input history queues, three-cycle pipeline
  logic c_h[$], d_h[$], e_h[$];
  int   m_cnt;
  logic [7:0] m_tx, m_sh, m_byte;
  logic m_pull, m_stb;

  always @(posedge clk) begin
    if (!rst_n) begin
      c_h = '{0, 0, 0}; d_h = '{0, 0, 0}; e_h = '{0, 0, 0};
      m_cnt = 0; m_tx = 0; m_sh = 0; m_byte = 0; m_pull = 0; m_stb = 0;
    end else begin
      m_stb = 1'b0;
      if (!e_h[1]) begin
        m_cnt = 0; m_pull = 1'b0; m_tx = txb;
      end else if (c_h[1] && !c_h[2]) begin
        m_pull = m_tx[7];
      end else if (!c_h[1] && c_h[2]) begin
        m_pull = 1'b0;
        m_sh = {m_sh[6:0], ~d_h[1]};
        if (m_cnt == 7) begin
          m_cnt = 0; m_byte = m_sh; m_stb = 1'b1; m_tx = txb;
        end else begin
          m_cnt++; m_tx = m_tx << 1;
        end
      end
      c_h.push_front(bclk); void'(c_h.pop_back());
      d_h.push_front(bdat); void'(d_h.pop_back());
      e_h.push_front(ben);  void'(e_h.pop_back());
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (stb) begin stb_cnt++; last_rx = rxb; end
    if (rst_n && cyc > 2) begin
      chk(pull == m_pull, "R9 R4 pull vs model", pull, m_pull);
      chk(stb == m_stb, "R9 R3 strobe vs model", stb, m_stb);
      chk(rxb == m_byte, "R9 R2 rx_byte vs model", rxb, m_byte);
    end
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // master clocks nbits bits; records what the block drove at each fall
  task automatic xfer(input logic [7:0] mb, input logic [7:0] nxt, input int nbits,
                      output logic [7:0] seen);
    seen = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk);
      bclk = 1'b1; mlow = mb[i];
      repeat (10) @(negedge clk);
      if (i == 7) txb = nxt;
      seen[i] = pull;
      bclk = 1'b0;
      repeat (10) @(negedge clk);
      mlow = 1'b0;
    end
  endtask

  initial begin
    logic [7:0] seen;
    int         base;
    repeat (5) @(negedge clk);
    // R1 during reset
    chk(pull == 0, "R1 pull in reset", pull, 0);
    chk(rxb == 0, "R1 rx in reset", rxb, 0);
    chk(stb == 0, "R1 strobe in reset", stb, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(pull == 0 && stb == 0 && rxb == 0, "R1 after release", {pull, stb, rxb}, 0);

    txb = 8'h00; ben = 1'b1;
    repeat (10) @(negedge clk);
    base = stb_cnt;
    xfer(8'hA5, 8'h3C, 8, seen);
    chk(seen == 8'h00, "R5 zero byte never pulls", seen, 8'h00);
    chk(last_rx == 8'hA5, "R2 master byte received", last_rx, 8'hA5);
    chk(stb_cnt == base + 1, "R3 one strobe per byte", stb_cnt, base + 1);

    xfer(8'h00, 8'h18, 8, seen);
    chk(seen == 8'h3C, "R4 transmit bits MSB first", seen, 8'h3C);
    chk(last_rx == 8'h3C, "R2 own bits read back", last_rx, 8'h3C);

    xfer(8'h81, 8'h00, 8, seen);
    chk(seen == 8'h18, "R6 next byte taken at strobe", seen, 8'h18);
    chk(last_rx == 8'h99, "R5 wired-AND merge", last_rx, 8'h99);
    chk(stb_cnt == base + 3, "R3 strobe count", stb_cnt, base + 3);

    // R7 abandon mid byte
    base = stb_cnt;
    xfer(8'hFF, 8'h00, 4, seen);
    ben = 1'b0;
    repeat (10) @(negedge clk);
    chk(pull == 0, "R7 line released", pull, 0);
    chk(stb_cnt == base, "R7 no strobe", stb_cnt, base);
    // R8 edges ignored while disabled
    xfer(8'hFF, 8'h00, 3, seen);
    chk(seen == 8'h00, "R8 no pull when off", seen, 0);
    chk(stb_cnt == base && rxb == 8'h99, "R8 rx unchanged", rxb, 8'h99);

    txb = 8'hC3;
    repeat (5) @(negedge clk);
    ben = 1'b1;
    repeat (10) @(negedge clk);
    xfer(8'h0F, 8'h00, 8, seen);
    chk(seen == 8'hC3, "R6 byte taken while disabled", seen, 8'hC3);
    chk(last_rx == 8'hCF, "R7 restart from first bit", last_rx, 8'hCF);
    chk(stb_cnt == base + 1, "R7 one strobe after restart", stb_cnt, base + 1);

    xfer(8'h00, 8'h00, 8, seen);
    chk(seen == 8'h00 && last_rx == 8'h00, "R5 idle byte", last_rx, 0);

    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule